// File: doc/BRIEF.md
# Two-Bank Edge/Level Interrupt Controller

This block gathers up to 64 interrupt lines, split into banks of 32, and raises one request to the processor when an enabled source needs service. Each line is either edge-type or level-type. The choice is fixed by a per-bank parameter mask. An edge-type line records a rising edge in a sticky event bit, and software clears that bit with a write-one-to-clear acknowledge. A level-type line is never latched. It counts as pending for as long as its input is high and its enable bit is set.

Software reaches the controller over a simple single-cycle register bus. Each bank has four word registers: event, enable, acknowledge and the live input state. As a convenience, the controller also presents the number of the highest pending line and a valid flag. Software can therefore pick a source without scanning the banks.

Inputs are asynchronous. They pass through a synchronizer before any edge detection. Turning on the enable of a line that is already high does not create an event.

Top module: `lic_ctrl`

## Requirements
- R1: After reset every enable and event bit reads 0, `irq_out` and `vec_valid` are 0, and `vec_num` is 0.
- R2: Bank b occupies the 16 bytes at offset (NUM_BANKS-b)*0x10, so bank 0 (lines 0-31) is at 0x20 and bank 1 (lines 32-63) is at 0x10. Within a bank, address bits [3:2] select the register: 0 event, 1 enable, 2 acknowledge, 3 level. Read data arrives on the cycle after `bus_rd`, flagged by `bus_rvalid`. Reading the acknowledge register or any unmapped offset returns 0.
- R3: The enable register reads back exactly the value last written to it.
- R4: An edge-type line sets its event bit on a rising edge of its synchronized input only while its enable bit is 1. The bit then stays set after the input falls, until it is acknowledged. A rising edge while the line is disabled leaves the bit at 0.
- R5: Setting an enable bit while its input is already high sets no event bit and raises no request.
- R6: Writing 1 to a bit of the acknowledge register clears that event bit, and writing 0 leaves it unchanged. If a new rising edge reaches the same bit in the cycle of the acknowledge write, the bit stays set.
- R7: The level register returns the synchronized state of all 32 inputs of its bank, whether or not they are enabled.
- R8: Lines whose bit is set in LEVEL_MASK (bank 0 default 0x3FF00000, lines 20-29) never set an event bit. They are pending exactly while the input is high and enabled.
- R9: `irq_out` is 1 when any bank has a line in (event OR (input AND level mask)) AND enable. After zero is written to every enable register, `irq_out` is 0.
- R10: `vec_num` gives the highest-numbered pending line, searching bank 1 before bank 0, and `vec_valid` is 1 with it. When nothing is pending, both are 0.
- R11: `irq_out`, `vec_valid` and `vec_num` are registered. They reflect an enable write one clock edge after the edge that stores that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 64 | Asynchronous interrupt source lines |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 6 | Byte address within the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after bus_rd |
| irq_out | output | 1 | Interrupt request |
| vec_valid | output | 1 | A line is pending |
| vec_num | output | 6 | Highest pending line number |

## Verification
An input change takes two clock edges to cross the synchronizer. An edge event is stored on the third edge and shows on `irq_out` on the fourth, while a level line shows on the third. Read data is due one edge after the strobe, and a change of enable is visible on `irq_out` one edge after the write is stored. The scoreboard queues the expected word for every read and compares it in the cycle `bus_rvalid` rises. The bench samples at falling edges: it waits a settled interval after input changes, and it checks exact cycles only for the enable-to-request latency and for the acknowledge-versus-edge race, where it places the acknowledge write on the edge that stores the event.

// File: rtl/lic_pkg.sv
package lic_pkg;

  localparam int LIC_WORD = 32;

  // register select inside a bank (address bits [3:2])
  typedef enum logic [1:0] {
    REG_EVENT  = 2'd0,
    REG_ENABLE = 2'd1,
    REG_ACK    = 2'd2,
    REG_LEVEL  = 2'd3
  } lic_reg_e;

  // slot number (address bits above the register field) of bank b
  function automatic int bank_slot(input int num_banks, input int b);
    return num_banks - b;
  endfunction

endpackage

// File: rtl/lic_sync.sv
module lic_sync #(
  parameter int WIDTH  = 64,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] d_sync
);

  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d_async;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign d_sync = stg[STAGES-1];

endmodule

// File: rtl/lic_bank.sv
module lic_bank #(
  parameter int                 LINES    = 32,
  parameter logic [LINES-1:0]   LVL_MASK = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LINES-1:0] line_sync,
  input  logic             en_we,
  input  logic             ack_we,
  input  logic [LINES-1:0] wdata,
  output logic [LINES-1:0] event_q,
  output logic [LINES-1:0] enable_q,
  output logic [LINES-1:0] pending
);

  localparam logic [LINES-1:0] EDGE_LINES = ~LVL_MASK;

  logic [LINES-1:0] prev_q;
  logic [LINES-1:0] rise;
  logic [LINES-1:0] ack_bits;
  logic [LINES-1:0] event_d;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= line_sync;
  end

  always_ff @(posedge clk) begin
    if (rst)        enable_q <= '0;
    else if (en_we) enable_q <= wdata;
  end

  // a new edge is ORed in after the clear, so it survives a same-cycle ack
  always_comb begin
    rise     = line_sync & ~prev_q;
    ack_bits = ack_we ? wdata : '0;
    event_d  = ((event_q & ~ack_bits) | (rise & enable_q)) & EDGE_LINES;
  end

  always_ff @(posedge clk) begin
    if (rst) event_q <= '0;
    else     event_q <= event_d;
  end

  assign pending = (event_q | (line_sync & LVL_MASK)) & enable_q;

endmodule

// File: rtl/lic_prio.sv
module lic_prio #(
  parameter int N     = 64,
  parameter int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     req,
  output logic             found,
  output logic [IDX_W-1:0] idx
);

  // scan upward: the last hit is the highest line, so upper banks win
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = 0; i < N; i++) begin
      if (req[i]) begin
        found = 1'b1;
        idx   = IDX_W'(i);
      end
    end
  end

endmodule

// File: rtl/lic_ctrl.sv
module lic_ctrl
  import lic_pkg::*;
#(
  parameter int                         NUM_BANKS   = 2,
  parameter int                         SYNC_STAGES = 2,
  parameter logic [NUM_BANKS*32-1:0]    LEVEL_MASK  = 64'h0000_0000_3FF0_0000,
  localparam int                        LINES       = NUM_BANKS * LIC_WORD,
  localparam int                        ADDR_W      = $clog2((NUM_BANKS + 1) * 16),
  localparam int                        VEC_W       = $clog2(LINES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [LINES-1:0]  irq_in,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              bus_rvalid,
  output logic              irq_out,
  output logic              vec_valid,
  output logic [VEC_W-1:0]  vec_num
);

  localparam int SLOT_W = ADDR_W - 4;

  logic [LINES-1:0] line_sync;
  logic [LINES-1:0] ev_all;
  logic [LINES-1:0] en_all;
  logic [LINES-1:0] pend_all;
  logic [NUM_BANKS-1:0] bank_hit;
  logic [SLOT_W-1:0] slot;
  lic_reg_e          rsel;
  logic [31:0]       rd_word;
  logic              pr_found;
  logic [VEC_W-1:0]  pr_idx;

  assign slot = bus_addr[ADDR_W-1:4];
  assign rsel = lic_reg_e'(bus_addr[3:2]);

  lic_sync #(.WIDTH(LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .d_async (irq_in),
    .d_sync  (line_sync)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam int SLOT = bank_slot(NUM_BANKS, b);
    assign bank_hit[b] = (int'(slot) == SLOT);

    lic_bank #(.LINES(LIC_WORD), .LVL_MASK(LEVEL_MASK[b*LIC_WORD +: LIC_WORD])) u_bank (
      .clk       (clk),
      .rst       (rst),
      .line_sync (line_sync[b*LIC_WORD +: LIC_WORD]),
      .en_we     (bus_wr && bank_hit[b] && (rsel == REG_ENABLE)),
      .ack_we    (bus_wr && bank_hit[b] && (rsel == REG_ACK)),
      .wdata     (bus_wdata),
      .event_q   (ev_all[b*LIC_WORD +: LIC_WORD]),
      .enable_q  (en_all[b*LIC_WORD +: LIC_WORD]),
      .pending   (pend_all[b*LIC_WORD +: LIC_WORD])
    );
  end

  // read mux: unmapped slots and the acknowledge register give zero
  always_comb begin
    rd_word = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (bank_hit[b]) begin
        unique case (rsel)
          REG_EVENT:  rd_word = ev_all[b*LIC_WORD +: LIC_WORD];
          REG_ENABLE: rd_word = en_all[b*LIC_WORD +: LIC_WORD];
          REG_ACK:    rd_word = '0;
          REG_LEVEL:  rd_word = line_sync[b*LIC_WORD +: LIC_WORD];
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rvalid <= 1'b0;
      bus_rdata  <= '0;
    end else begin
      bus_rvalid <= bus_rd;
      bus_rdata  <= bus_rd ? rd_word : '0;
    end
  end

  lic_prio #(.N(LINES), .IDX_W(VEC_W)) u_prio (
    .req   (pend_all),
    .found (pr_found),
    .idx   (pr_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_out   <= 1'b0;
      vec_valid <= 1'b0;
      vec_num   <= '0;
    end else begin
      irq_out   <= |pend_all;
      vec_valid <= pr_found;
      vec_num   <= pr_idx;
    end
  end

endmodule

// File: rtl/lic_ctrl_chk.sv
module lic_ctrl_chk #(
  parameter int ADDR_W = 6,
  parameter int VEC_W  = 6
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_rdata,
  input logic              bus_rvalid,
  input logic              irq_out,
  input logic              vec_valid,
  input logic [VEC_W-1:0]  vec_num
);

  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> (!irq_out && !vec_valid && vec_num == '0));

  p_read_latency_r2: assert property (@(posedge clk) disable iff (rst)
    bus_rd |=> bus_rvalid);

  p_idle_data_r2: assert property (@(posedge clk) disable iff (rst)
    !bus_rvalid |-> bus_rdata == '0);

  p_ack_reads_zero_r6: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr[3:2] == 2'd2) |=> bus_rdata == '0);

  p_irq_has_vector_r10: assert property (@(posedge clk) disable iff (rst)
    irq_out |-> vec_valid);

  p_idle_vector_r10: assert property (@(posedge clk) disable iff (rst)
    !vec_valid |-> (vec_num == '0 && !irq_out));

endmodule

bind lic_ctrl lic_ctrl_chk #(.ADDR_W(ADDR_W), .VEC_W(VEC_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .bus_rd     (bus_rd),
  .bus_addr   (bus_addr),
  .bus_rdata  (bus_rdata),
  .bus_rvalid (bus_rvalid),
  .irq_out    (irq_out),
  .vec_valid  (vec_valid),
  .vec_num    (vec_num)
);

// File: tb/lic_ctrl_bench.sv
module lic_ctrl_bench;

  localparam logic [5:0] EV0 = 6'h20, EN0 = 6'h24, AK0 = 6'h28, LV0 = 6'h2C;
  localparam logic [5:0] EV1 = 6'h10, EN1 = 6'h14, AK1 = 6'h18, LV1 = 6'h1C;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] irq_in = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic        irq_out;
  logic        vec_valid;
  logic [5:0]  vec_num;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [31:0] exp_q [$];
  string       tag_q [$];

  always #5 clk = ~clk;

  lic_ctrl u_lic_ctrl (
    .clk        (clk),
    .rst        (rst),
    .irq_in     (irq_in),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .bus_rvalid (bus_rvalid),
    .irq_out    (irq_out),
    .vec_valid  (vec_valid),
    .vec_num    (vec_num)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  // driver: push the expected word, monitor compares when data returns
  task automatic rd(input logic [5:0] a, input logic [31:0] e, input string tag);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic line(input int n, input logic v);
    @(negedge clk);
    irq_in[n] = v;
  endtask

  task automatic chk_out(input string tag, input logic irq, input logic vv, input logic [5:0] vn);
    chk({tag, " irq_out"}, {31'd0, irq_out}, {31'd0, irq});
    chk({tag, " vec_valid"}, {31'd0, vec_valid}, {31'd0, vv});
    chk({tag, " vec_num"}, {26'd0, vec_num}, {26'd0, vn});
  endtask

  // monitor
  always @(negedge clk) begin
    if (!rst && bus_rvalid) begin
      if (exp_q.size() == 0) begin
        checks++; fails++;
        $display("FAIL R2: unexpected read data 0x%08h expected none", bus_rdata);
      end else begin
        chk(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    wait_n(3);
    rst = 1'b0;
    wait_n(1);
    // R1 reset state
    chk_out("R1 reset", 1'b0, 1'b0, 6'd0);
    rd(EN0, 32'h0, "R1 enable0 after reset");
    rd(EV1, 32'h0, "R1 event1 after reset");
    // R2 unmapped offsets and acknowledge read
    rd(6'h00, 32'h0, "R2 unmapped 0x00");
    rd(6'h30, 32'h0, "R2 unmapped 0x30");
    rd(AK0, 32'h0, "R2 ack reads zero");
    // R3 readback
    wr(EN0, 32'hA5A5_0F0F);
    rd(EN0, 32'hA5A5_0F0F, "R3 enable0 readback");
    wr(EN1, 32'h1234_8001);
    rd(EN1, 32'h1234_8001, "R3 enable1 readback");
    wr(EN1, 32'h0);
    wr(EN0, 32'h0000_0001);
    // R4 edge latch, sticky
    line(0, 1'b1); wait_n(6);
    chk_out("R4 edge pending", 1'b1, 1'b1, 6'd0);
    rd(EV0, 32'h1, "R4 event set");
    line(0, 1'b0); wait_n(6);
    rd(EV0, 32'h1, "R4 event sticky after fall");
    chk_out("R4 still pending", 1'b1, 1'b1, 6'd0);
    // R6 acknowledge
    wr(AK0, 32'h0); wait_n(4);
    rd(EV0, 32'h1, "R6 ack zero no effect");
    wr(AK0, 32'h1); wait_n(4);
    rd(EV0, 32'h0, "R6 ack one clears");
    chk_out("R6 quiet after ack", 1'b0, 1'b0, 6'd0);
    // R4 disabled edge, R5 enable while high
    line(5, 1'b1); wait_n(6);
    rd(EV0, 32'h0, "R4 disabled edge ignored");
    wr(EN0, 32'h0000_0021); wait_n(6);
    rd(EV0, 32'h0, "R5 enable while high no event");
    chk_out("R5 no request", 1'b0, 1'b0, 6'd0);
    line(5, 1'b0);
    // R7 level register shows raw inputs
    line(3, 1'b1); line(40, 1'b1); wait_n(6);
    rd(LV0, 32'h0000_0008, "R7 level bank0");
    rd(LV1, 32'h0000_0100, "R7 level bank1");
    // R8 level line 22
    wr(EN0, 32'h0040_0021);
    line(22, 1'b1); wait_n(6);
    rd(EV0, 32'h0, "R8 level line no event");
    chk_out("R8 level pending", 1'b1, 1'b1, 6'd22);
    line(22, 1'b0); wait_n(6);
    chk_out("R8 level released", 1'b0, 1'b0, 6'd0);
    // R5 on bank1 with line 40 already high
    wr(EN1, 32'hFFFF_FFFF); wait_n(6);
    chk_out("R5 bank1 enable while high", 1'b0, 1'b0, 6'd0);
    line(40, 1'b0); line(3, 1'b0); wait_n(4);
    // R10 priority
    line(33, 1'b1); wait_n(6);
    chk_out("R10 line33", 1'b1, 1'b1, 6'd33);
    line(0, 1'b1); wait_n(6);
    chk_out("R10 bank1 before bank0", 1'b1, 1'b1, 6'd33);
    line(62, 1'b1); wait_n(6);
    chk_out("R10 highest line", 1'b1, 1'b1, 6'd62);
    rd(EV1, 32'h4000_0002, "R10 event1 two lines");
    wr(AK1, 32'h4000_0000); wait_n(3);
    chk_out("R10 after ack 62", 1'b1, 1'b1, 6'd33);
    wr(AK1, 32'h0000_0002); wait_n(3);
    chk_out("R10 bank0 only", 1'b1, 1'b1, 6'd0);
    wr(AK0, 32'h0000_0001); wait_n(3);
    chk_out("R10 none pending", 1'b0, 1'b0, 6'd0);
    // R6 race: acknowledge on the edge that stores a new event
    line(33, 1'b0); wait_n(6);
    line(33, 1'b1); wait_n(6);
    line(33, 1'b0); wait_n(6);
    rd(EV1, 32'h0000_0002, "R6 race setup");
    @(negedge clk); irq_in[33] = 1'b1;
    @(negedge clk);
    @(negedge clk); bus_wr = 1'b1; bus_addr = AK1; bus_wdata = 32'h2;
    @(negedge clk); bus_wr = 1'b0;
    wait_n(3);
    rd(EV1, 32'h0000_0002, "R6 new edge wins over ack");
    wr(AK1, 32'h2); wait_n(3);
    rd(EV1, 32'h0, "R6 cleared after race");
    // R11 latency of enable to request, level line 25
    line(25, 1'b1); wait_n(6);
    chk_out("R11 before enable", 1'b0, 1'b0, 6'd0);
    @(negedge clk); bus_wr = 1'b1; bus_addr = EN0; bus_wdata = 32'h0240_0021;
    @(negedge clk); bus_wr = 1'b0;
    chk_out("R11 one edge after write", 1'b0, 1'b0, 6'd0);
    @(negedge clk);
    chk_out("R11 two edges after write", 1'b1, 1'b1, 6'd25);
    // R9 all enables off
    wr(EN0, 32'h0); wr(EN1, 32'h0); wait_n(3);
    chk_out("R9 enables cleared", 1'b0, 1'b0, 6'd0);
    line(25, 1'b0); line(33, 1'b0); line(62, 1'b0); line(0, 1'b0);
    wait_n(6);
    if (exp_q.size() != 0) begin
      checks++; fails++;
      $display("FAIL R2: actual %0d reads outstanding expected 0", exp_q.size());
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule